// File: doc/BRIEF.md
# Keyboard Input Port with Memory-Mapped Registers

This block sits on a simple processor bus and makes a keyboard's characters available to software through two byte-wide registers at fixed addresses. A character register holds the code of the most recent key. A control/status register reports whether an unread character is waiting, whether an interrupt is pending, and whether a character was lost. It also holds the one software-writable interrupt enable.

Key codes arrive already decoded, as an 8-bit code with a one-cycle valid strobe. Each arrival loads the character register and sets the ready and pending-interrupt flags. A processor read of the character register consumes the character and clears both flags. The interrupt request output is high while an interrupt is pending and interrupts are enabled. Bus reads return data combinationally in the cycle the read strobe is high, and any side effect of the read takes hold at the next clock edge.

Top module: `kbd_port_top`

## Requirements
- R1: After reset, the character register reads 0x00, the status register reads 0x00 and the interrupt request is low.
- R2: A cycle with the key valid strobe high loads the key code into the character register, and the code is returned by a read of address 5000 from the next cycle on.
- R3: A key arrival sets the ready bit, bit 7 of the status register at address 5002, from the next cycle on.
- R4: A key arrival sets the pending-interrupt bit, status bit 1. The interrupt request output is high exactly while status bit 1 and status bit 0 are both 1.
- R5: A write to address 5002 loads status bit 0 (interrupt enable) from bit 0 of the write data, which enables or masks the interrupt request from the next cycle on.
- R6: A read of address 5000 clears the ready and pending-interrupt bits from the next cycle on, unless a key arrives in the same cycle.
- R7: A key arriving while the ready bit is set overwrites the character and sets the overrun bit, status bit 6. The overrun bit stays set until a read of address 5002 clears it, and that read still returns it as 1.
- R8: Writes to address 5000 leave the character register unchanged. Write data bits 7 to 1 sent to address 5002 leave the ready, overrun and pending-interrupt bits unchanged.
- R9: Status bits 5 to 2 always read 0. A read of any address other than 5000 or 5002, and any cycle without a read strobe, returns 0x00.
- R10: If a key arrives in the same cycle as a read of address 5000, the read returns the old character. The new character is then held with ready set and the overrun bit not set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| busAddr | input | 16 | Byte address of the bus access |
| busWrData | input | 8 | Write data |
| busRd | input | 1 | Read strobe, one access per cycle |
| busWr | input | 1 | Write strobe, one access per cycle |
| busRdData | output | 8 | Read data, valid in the cycle busRd is high |
| keyValid | input | 1 | One-cycle strobe marking a new key code |
| keyCode | input | 8 | Parallel key code |
| irq | output | 1 | Interrupt request |

## Verification
A single key followed by a character read shows the basic load-and-consume path. It also shows that ready and the interrupt flag clear together. Two keys with no read in between separate overwrite-with-overrun from a plain load, and the overrun-then-clear sequence of status reads shows that the read returns the bit before clearing it. A key that arrives in the same cycle as a character read tells apart a design that lets the read win from one that keeps the new character. Writes to the character address, writes of all-ones to status, and reads of neighbouring addresses show that nothing outside the defined fields moves.

// File: rtl/kbd_port_pkg.sv
package kbd_port_pkg;

  localparam int CODE_W     = 8;
  localparam int READY_POS  = 7;
  localparam int OVRUN_POS  = 6;
  localparam int PEND_POS   = 1;
  localparam int ENABLE_POS = 0;

  typedef struct packed {
    logic loadKey;
    logic setOverrun;
    logic clrReady;
    logic clrOverrun;
    logic writeEnable;
    logic selChar;
    logic selStatus;
  } kbdStrobe_t;

endpackage

// File: rtl/kbd_port_ctrl.sv
module kbd_port_ctrl
  import kbd_port_pkg::*;
#(
  parameter int          ADDR_W    = 16,
  parameter logic [15:0] CHAR_ADDR = 16'd5000,
  parameter logic [15:0] STAT_ADDR = 16'd5002
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busRd,
  input  logic              busWr,
  input  logic              keyValid,
  input  logic              readyQ,
  input  logic              overrunQ,
  output kbdStrobe_t        strb
);

  localparam logic [ADDR_W-1:0] CharHit = ADDR_W'(CHAR_ADDR);
  localparam logic [ADDR_W-1:0] StatHit = ADDR_W'(STAT_ADDR);

  logic hitChar;
  logic hitStat;
  logic charRead;
  logic statRead;
  logic statWrite;

  always_comb begin
    hitChar   = (busAddr == CharHit);
    hitStat   = (busAddr == StatHit);
    charRead  = busRd & hitChar;
    statRead  = busRd & hitStat;
    statWrite = busWr & hitStat;
  end

  always_comb begin
    strb             = '0;
    strb.loadKey     = keyValid;
    strb.setOverrun  = keyValid & readyQ & ~charRead;
    strb.clrReady    = charRead & ~keyValid;
    strb.clrOverrun  = statRead & ~strb.setOverrun;
    strb.writeEnable = statWrite;
    strb.selChar     = charRead;
    strb.selStatus   = statRead;
  end

  // R7: a key landing on an unread character must leave overrun set
  assert_overrun_on_collision_R7: assert property (@(posedge clk) disable iff (!rstN)
    (keyValid && readyQ && !charRead) |=> overrunQ);

  // R10: a key arriving together with a character read must not flag overrun
  assert_no_overrun_on_race_R10: assert property (@(posedge clk) disable iff (!rstN)
    (keyValid && charRead && !overrunQ) |=> (readyQ && !overrunQ));

endmodule

// File: rtl/kbd_port_dp.sv
module kbd_port_dp
  import kbd_port_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  kbdStrobe_t        strb,
  input  logic [CODE_W-1:0] keyCode,
  input  logic [7:0]        busWrData,
  output logic [7:0]        busRdData,
  output logic              readyQ,
  output logic              overrunQ,
  output logic              irq
);

  logic [CODE_W-1:0] charReg;
  logic              pendQ;
  logic              enableQ;
  logic [7:0]        statusByte;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      charReg <= '0;
    end else if (strb.loadKey) begin
      charReg <= keyCode;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      readyQ <= 1'b0;
      pendQ  <= 1'b0;
    end else if (strb.loadKey) begin
      readyQ <= 1'b1;
      pendQ  <= 1'b1;
    end else if (strb.clrReady) begin
      readyQ <= 1'b0;
      pendQ  <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      overrunQ <= 1'b0;
    end else if (strb.setOverrun) begin
      overrunQ <= 1'b1;
    end else if (strb.clrOverrun) begin
      overrunQ <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enableQ <= 1'b0;
    end else if (strb.writeEnable) begin
      enableQ <= busWrData[ENABLE_POS];
    end
  end

  always_comb begin
    statusByte             = '0;
    statusByte[READY_POS]  = readyQ;
    statusByte[OVRUN_POS]  = overrunQ;
    statusByte[PEND_POS]   = pendQ;
    statusByte[ENABLE_POS] = enableQ;
  end

  always_comb begin
    busRdData = '0;
    if (strb.selChar) begin
      busRdData = charReg;
    end else if (strb.selStatus) begin
      busRdData = statusByte;
    end
  end

  assign irq = pendQ & enableQ;

  // R2: an arrival lands in the character register
  assert_char_loaded_R2: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadKey |=> (charReg == $past(keyCode)));

  // R3: an arrival raises ready
  assert_ready_after_key_R3: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadKey |=> readyQ);

  // R6: a consuming read drops ready and the pending flag
  assert_read_clears_R6: assert property (@(posedge clk) disable iff (!rstN)
    strb.clrReady |=> (!readyQ && !pendQ));

  // R5: the enable bit follows the written data bit
  assert_enable_written_R5: assert property (@(posedge clk) disable iff (!rstN)
    strb.writeEnable |=> (enableQ == $past(busWrData[ENABLE_POS])));

  // R8: without an arrival the character register never moves
  assert_char_stable_R8: assert property (@(posedge clk) disable iff (!rstN)
    !strb.loadKey |=> $stable(charReg));

  // R4: a request is never raised without a pending flag
  assert_irq_needs_pend_R4: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (pendQ && readyQ));

endmodule

// File: rtl/kbd_port_top.sv
module kbd_port_top
  import kbd_port_pkg::*;
#(
  parameter int          ADDR_W    = 16,
  parameter logic [15:0] CHAR_ADDR = 16'd5000,
  parameter logic [15:0] STAT_ADDR = 16'd5002
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [7:0]        busWrData,
  input  logic              busRd,
  input  logic              busWr,
  output logic [7:0]        busRdData,
  input  logic              keyValid,
  input  logic [CODE_W-1:0] keyCode,
  output logic              irq
);

  kbdStrobe_t strb;
  logic       readyQ;
  logic       overrunQ;

  kbd_port_ctrl #(
    .ADDR_W   (ADDR_W),
    .CHAR_ADDR(CHAR_ADDR),
    .STAT_ADDR(STAT_ADDR)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .busAddr (busAddr),
    .busRd   (busRd),
    .busWr   (busWr),
    .keyValid(keyValid),
    .readyQ  (readyQ),
    .overrunQ(overrunQ),
    .strb    (strb)
  );

  kbd_port_dp u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .keyCode  (keyCode),
    .busWrData(busWrData),
    .busRdData(busRdData),
    .readyQ   (readyQ),
    .overrunQ (overrunQ),
    .irq      (irq)
  );

  // R9: no read strobe, no data on the bus
  assert_idle_bus_zero_R9: assert property (@(posedge clk) disable iff (!rstN)
    !busRd |-> (busRdData == 8'h00));

endmodule

// File: tb/tb_kbd_port_top.sv
module tb_kbd_port_top;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] busAddr = '0;
  logic [7:0]  busWrData = '0;
  logic        busRd = 1'b0;
  logic        busWr = 1'b0;
  logic [7:0]  busRdData;
  logic        keyValid = 1'b0;
  logic [7:0]  keyCode = '0;
  logic        irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // behavioural reference state
  int mChar  = 0;
  bit mReady = 0;
  bit mPend  = 0;
  bit mOvr   = 0;
  bit mEn    = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  kbd_port_top dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrData(busWrData),
    .busRd(busRd), .busWr(busWr), .busRdData(busRdData),
    .keyValid(keyValid), .keyCode(keyCode), .irq(irq)
  );

  function automatic int expRead(bit rd, int addr);
    if (!rd) return 0;
    if (addr == 5000) return mChar;
    if (addr == 5002) return (mReady << 7) | (mOvr << 6) | (mPend << 1) | int'(mEn);
    return 0;
  endfunction

  task automatic check(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  task automatic cyc(string tag, bit rd, bit wr, int addr, int wdata, bit kv, int kc);
    bit charRd;
    busRd = rd; busWr = wr; busAddr = 16'(addr); busWrData = 8'(wdata);
    keyValid = kv; keyCode = 8'(kc);
    #1;
    check(tag, "rdData", int'(busRdData), expRead(rd, addr));
    check(tag, "irq", int'(irq), int'(mPend & mEn));
    @(posedge clk);
    charRd = rd && addr == 5000;
    if (rd && addr == 5002 && !(kv && mReady && !charRd)) mOvr = 0;
    if (kv && mReady && !charRd) mOvr = 1;
    if (kv) begin mChar = kc; mReady = 1; mPend = 1; end
    else if (charRd) begin mReady = 0; mPend = 0; end
    if (wr && addr == 5002) mEn = wdata[0];
    @(negedge clk);
    busRd = 0; busWr = 0; keyValid = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    cyc("R1", 1, 0, 5000, 0, 0, 0);
    cyc("R1", 1, 0, 5002, 0, 0, 0);
    // R2 R3 R4 single key with interrupts masked
    cyc("R2", 0, 0, 0, 0, 1, 8'h41);
    cyc("R3", 1, 0, 5002, 0, 0, 0);
    cyc("R2", 1, 0, 5000, 0, 0, 0);
    // R5 enable, R8 other status bits written with ones are ignored
    cyc("R4", 0, 0, 0, 0, 1, 8'h42);
    cyc("R5", 0, 1, 5002, 8'hFF, 0, 0);
    cyc("R8", 1, 0, 5002, 0, 0, 0);
    // R6 consuming read drops ready, pending and irq
    cyc("R6", 1, 0, 5000, 0, 0, 0);
    cyc("R6", 1, 0, 5002, 0, 0, 0);
    // R7 two keys without a read
    cyc("R7", 0, 0, 0, 0, 1, 8'h10);
    cyc("R7", 0, 0, 0, 0, 1, 8'h20);
    cyc("R7", 1, 0, 5000, 0, 0, 0);
    cyc("R7", 1, 0, 5002, 0, 0, 0);
    cyc("R7", 1, 0, 5002, 0, 0, 0);
    // R8 write to character address ignored
    cyc("R8", 0, 1, 5000, 8'h99, 0, 0);
    cyc("R8", 1, 0, 5000, 0, 0, 0);
    // R9 other addresses read zero
    cyc("R9", 1, 0, 5001, 0, 0, 0);
    cyc("R9", 1, 0, 5003, 0, 0, 0);
    cyc("R9", 1, 0, 4999, 0, 0, 0);
    // R10 arrival and character read in one cycle
    cyc("R10", 0, 0, 0, 0, 1, 8'h33);
    cyc("R10", 1, 0, 5000, 0, 1, 8'h55);
    cyc("R10", 1, 0, 5002, 0, 0, 0);
    cyc("R10", 1, 0, 5000, 0, 0, 0);
    // R5 masking drops irq while flag remains
    cyc("R5", 0, 0, 0, 0, 1, 8'h66);
    cyc("R5", 0, 1, 5002, 8'h00, 0, 0);
    cyc("R5", 1, 0, 5002, 0, 0, 0);
    // R7 status read racing a colliding arrival keeps overrun
    cyc("R7", 1, 0, 5002, 0, 1, 8'h77);
    cyc("R7", 1, 0, 5002, 0, 0, 0);
    cyc("R9", 0, 0, 0, 0, 0, 0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule